// File: doc/BRIEF.md
# Eight-Way Write-Back Data Cache Controller

This block sits between a processor load/store port and a line-wide memory port. It holds 32 KB of data as 512 lines of 64 bytes, arranged as 64 sets of eight ways. Each request is looked up in one pass. The set index picks a row, all eight stored tags are compared with the request tag, and a hit is served with no wait state. A read hit returns the addressed 32-bit word. A write hit overwrites that word and marks the line dirty.

On a miss the processor port holds `cpu_ready` low until the request can complete. The victim is the lowest-numbered invalid way if the set has one, and otherwise the least recently used way. A dirty victim is first written to memory as a full line. The missing line is then fetched and installed, and the held request is served as a hit.

Write misses follow the `alloc_en` input. When it is high, the line is fetched and the word is then written into it. When it is low, the word goes straight to memory and nothing is installed. Only one miss is in progress at a time.

Top module: `cache_ctrl`

## Requirements
- R1: A processor address splits into a byte offset in bits [5:0], a set index in bits [11:6] and a tag in bits [31:12]. Bits [5:2] select the 32-bit word within the line, and a read returns exactly that word.
- R2: A request that hits has `cpu_ready` high in the same cycle that `cpu_valid` is presented, so it completes with zero wait cycles.
- R3: A write hit updates the cached word and marks the line dirty. It makes no memory transaction.
- R4: On a read miss, `cpu_ready` stays low while the line is fetched. The refill reads line address `cpu_addr[31:6]` with `mem_we` low, and the request then completes with the fetched word.
- R5: A write miss with `alloc_en`=1 fetches the line, then writes the word into the cache. The word is not written to memory.
- R6: A write miss with `alloc_en`=0 makes exactly one memory write and no refill. That write has line address `cpu_addr[31:6]`, a word mask `mem_wmask` with only bit `cpu_addr[5:2]` set, and the data in lane `cpu_addr[5:2]` (lane i is `mem_wdata[32*i+31:32*i]`). A later read of that address misses and returns the written value.
- R7: Replacement takes the lowest-numbered invalid way first, and otherwise the least recently used way. Recency is updated by every hit and every fill.
- R8: A victim that is valid and dirty is written back before the refill. The write-back carries the victim's own line address, all sixteen mask bits set and the line contents, and the refill request follows it directly.
- R9: A clean victim is replaced without any memory write.
- R10: After reset every valid bit is clear: `cpu_ready` is high when idle, `mem_req` is low, and the first access to any address misses.
- R11: Once raised, `mem_req` stays high with `mem_we` and `mem_addr` unchanged until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_en | input | 1 | 1 = allocate a line on a write miss, 0 = write the word through to memory |
| cpu_valid | input | 1 | Processor request present; held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | The request completes in this cycle |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ready` is high on a load |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write to memory, 0 = line read |
| mem_addr | output | 26 | Line address (byte address bits [31:6]) |
| mem_wmask | output | 16 | Per-word write enable for a memory write |
| mem_wdata | output | 512 | Line data for a memory write, word i in bits [32*i+31:32*i] |
| mem_ack | input | 1 | One-cycle completion of the current transaction |
| mem_rdata | input | 512 | Line data returned with `mem_ack` on a read |

## Verification
The hardest case to reach is a dirty line becoming the replacement victim. The stimulus has to fill all eight ways of one set with distinct tags, dirty one of them, and then keep it in use long enough that other lines age out before it. Only then can a stream of new tags push the dirty line to the bottom of the recency order. The bench drives one set through a scripted series of tags whose expected recency order is worked out by hand. It checks that the write-back carries the old line address before the refill request, and that the stored word survives the round trip to memory.

// File: rtl/cache_pkg.sv
// Shared geometry and state encoding for the data cache.
// Assumes power-of-two line size, set count and way count.
package cache_pkg;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int LINE_BYTES = 64;
    localparam int NUM_WAYS   = 8;
    localparam int NUM_SETS   = 64;

    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int SET_W   = $clog2(NUM_SETS);
    localparam int TAG_W   = ADDR_W - OFF_W - SET_W;
    localparam int WAY_W   = $clog2(NUM_WAYS);
    localparam int LINE_W  = LINE_BYTES * 8;
    localparam int WORDS   = LINE_W / WORD_W;
    localparam int WSEL_W  = $clog2(WORDS);
    localparam int BYTE_W  = $clog2(WORD_W / 8);
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int SLOT_W  = SET_W + WAY_W;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WBACK, ST_FILL, ST_WTHRU, ST_DONE
    } cc_state_t;
endpackage

// File: rtl/cache_tags.sv
// Per-way valid, dirty and tag storage with parallel tag compare.
// Assumes at most one of fill_en / dirty_en addresses a given way per cycle.
module cache_tags
    import cache_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SET_W-1:0]               set_i,
    input  logic [TAG_W-1:0]               tag_i,
    input  logic                           fill_en,
    input  logic [WAY_W-1:0]               fill_way,
    input  logic                           dirty_en,
    input  logic [WAY_W-1:0]               dirty_way,
    output logic [NUM_WAYS-1:0]            hit_vec,
    output logic [NUM_WAYS-1:0]            valid_vec,
    output logic [NUM_WAYS-1:0]            dirty_vec,
    output logic [NUM_WAYS-1:0][TAG_W-1:0] tag_vec
);
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [NUM_SETS-1:0] vld_q;
        logic [NUM_SETS-1:0] drt_q;
        logic [TAG_W-1:0]    tag_q [NUM_SETS];

        // valid and dirty flags: cleared by reset, set by fill / write hit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= '0;
                drt_q <= '0;
            end else if (fill_en && fill_way == WAY_W'(w)) begin
                vld_q[set_i] <= 1'b1;
                drt_q[set_i] <= 1'b0;
            end else if (dirty_en && dirty_way == WAY_W'(w)) begin
                drt_q[set_i] <= 1'b1;
            end
        end

        // tag capture on fill
        always_ff @(posedge clk) begin
            if (fill_en && fill_way == WAY_W'(w)) tag_q[set_i] <= tag_i;
        end

        assign valid_vec[w] = vld_q[set_i];
        assign dirty_vec[w] = drt_q[set_i];
        assign tag_vec[w]   = tag_q[set_i];
        assign hit_vec[w]   = vld_q[set_i] && (tag_q[set_i] == tag_i);
    end
endmodule

// File: rtl/cache_lru.sv
// True-LRU tracking: each set keeps an ordered list of way numbers,
// slot 0 most recent, last slot least recent. Reset loads 0..N-1.
module cache_lru
    import cache_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SET_W-1:0]               set_i,
    input  logic                           touch_en,
    input  logic [WAY_W-1:0]               touch_way,
    output logic [WAY_W-1:0]               lru_way,
    output logic [NUM_WAYS-1:0][WAY_W-1:0] order_o
);
    logic [NUM_WAYS-1:0][WAY_W-1:0] ord_q [NUM_SETS];
    logic [NUM_WAYS-1:0][WAY_W-1:0] nxt;
    int                             pos;

    // move the touched way to slot 0, shifting the more recent ones down
    always_comb begin
        pos = 0;
        for (int i = 0; i < NUM_WAYS; i++)
            if (ord_q[set_i][i] == touch_way) pos = i;
        nxt[0] = touch_way;
        for (int i = 1; i < NUM_WAYS; i++)
            nxt[i] = (i <= pos) ? ord_q[set_i][i-1] : ord_q[set_i][i];
    end

    // list storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++)
                for (int i = 0; i < NUM_WAYS; i++)
                    ord_q[s][i] <= WAY_W'(i);
        end else if (touch_en) begin
            ord_q[set_i] <= nxt;
        end
    end

    assign order_o = ord_q[set_i];
    assign lru_way = ord_q[set_i][NUM_WAYS-1];
endmodule

// File: rtl/cache_data.sv
// Line-wide data store, one entry per {set, way}. A full-line write
// (fill) takes precedence over a single-word write (store hit).
module cache_data
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic [SLOT_W-1:0] rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic [SLOT_W-1:0] wr_idx,
    input  logic              line_we,
    input  logic [LINE_W-1:0] line_d,
    input  logic              word_we,
    input  logic [WSEL_W-1:0] word_sel,
    input  logic [WORD_W-1:0] word_d
);
    logic [LINE_W-1:0] ln_q [NUM_SETS*NUM_WAYS];

    // write port: whole line or one word
    always_ff @(posedge clk) begin
        if (line_we)      ln_q[wr_idx] <= line_d;
        else if (word_we) ln_q[wr_idx][word_sel*WORD_W +: WORD_W] <= word_d;
    end

    assign rd_line = ln_q[rd_idx];
endmodule

// File: rtl/cache_ctrl.sv
// Top of the data cache: lookup, miss state machine and memory port.
// Assumes the processor holds cpu_* stable while cpu_ready is low and the
// memory answers each request with a single-cycle mem_ack.
module cache_ctrl
    import cache_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_en,
    input  logic               cpu_valid,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [WORD_W-1:0]  cpu_wdata,
    output logic               cpu_ready,
    output logic [WORD_W-1:0]  cpu_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [LADDR_W-1:0] mem_addr,
    output logic [WORDS-1:0]   mem_wmask,
    output logic [LINE_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [LINE_W-1:0]  mem_rdata
);
    cc_state_t                      state;
    logic [ADDR_W-1:0]              lk_addr;
    logic [WAY_W-1:0]               v_way;
    logic [TAG_W-1:0]               v_tag;
    logic [ADDR_W-1:0]              look_addr;
    logic [SET_W-1:0]               set_idx;
    logic [TAG_W-1:0]               req_tag;
    logic [WSEL_W-1:0]              wsel;
    logic [NUM_WAYS-1:0]            hit_vec, valid_vec, dirty_vec;
    logic [NUM_WAYS-1:0][TAG_W-1:0] tag_vec;
    logic [NUM_WAYS-1:0][WAY_W-1:0] lru_row;
    logic [WAY_W-1:0]               hit_way, lru_way, victim;
    logic                           hit, hit_acc, fill_en;
    logic [LINE_W-1:0]              rd_line;

    assign look_addr = (state == ST_IDLE) ? cpu_addr : lk_addr;
    assign set_idx   = look_addr[OFF_W +: SET_W];
    assign req_tag   = look_addr[ADDR_W-1 -: TAG_W];
    assign wsel      = look_addr[BYTE_W +: WSEL_W];

    // hit-way encode and victim pick (first invalid, else LRU)
    always_comb begin
        logic found;
        hit_way = '0;
        for (int w = 0; w < NUM_WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
        found  = 1'b0;
        victim = lru_way;
        for (int w = 0; w < NUM_WAYS; w++)
            if (!valid_vec[w] && !found) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
    end

    assign hit       = |hit_vec;
    assign hit_acc   = (state == ST_IDLE) && cpu_valid && hit;
    assign fill_en   = (state == ST_FILL) && mem_ack;
    assign cpu_ready = ((state == ST_IDLE) && (!cpu_valid || hit)) || (state == ST_DONE);
    assign cpu_rdata = rd_line[wsel*WORD_W +: WORD_W];

    // miss sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            lk_addr <= '0;
            v_way   <= '0;
            v_tag   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (cpu_valid && !hit) begin
                    lk_addr <= cpu_addr;
                    if (cpu_we && !alloc_en) begin
                        state <= ST_WTHRU;
                    end else begin
                        v_way <= victim;
                        v_tag <= tag_vec[victim];
                        state <= (valid_vec[victim] && dirty_vec[victim]) ? ST_WBACK : ST_FILL;
                    end
                end
                ST_WBACK: if (mem_ack) state <= ST_FILL;
                ST_FILL:  if (mem_ack) state <= ST_IDLE;
                ST_WTHRU: if (mem_ack) state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // memory port drive
    always_comb begin
        mem_req   = (state == ST_WBACK) || (state == ST_FILL) || (state == ST_WTHRU);
        mem_we    = (state == ST_WBACK) || (state == ST_WTHRU);
        mem_addr  = (state == ST_WBACK) ? {v_tag, set_idx} : look_addr[ADDR_W-1:OFF_W];
        mem_wmask = (state == ST_WTHRU) ? (WORDS'(1) << wsel) : '1;
        mem_wdata = (state == ST_WTHRU) ? {WORDS{cpu_wdata}} : rd_line;
    end

    cache_tags u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_idx),
        .tag_i     (req_tag),
        .fill_en   (fill_en),
        .fill_way  (v_way),
        .dirty_en  (hit_acc && cpu_we),
        .dirty_way (hit_way),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec),
        .dirty_vec (dirty_vec),
        .tag_vec   (tag_vec)
    );

    cache_lru u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_idx),
        .touch_en  (hit_acc || fill_en),
        .touch_way (hit_acc ? hit_way : v_way),
        .lru_way   (lru_way),
        .order_o   (lru_row)
    );

    cache_data u_data (
        .clk      (clk),
        .rd_idx   ({set_idx, (state == ST_WBACK) ? v_way : hit_way}),
        .rd_line  (rd_line),
        .wr_idx   ({set_idx, fill_en ? v_way : hit_way}),
        .line_we  (fill_en),
        .line_d   (mem_rdata),
        .word_we  (hit_acc && cpu_we),
        .word_sel (wsel),
        .word_d   (cpu_wdata)
    );
endmodule

// File: rtl/cache_ctrl_chk.sv
// Protocol and state checks for cache_ctrl, attached with bind.
// Assumes the memory side pulses mem_ack for exactly one cycle.
module cache_ctrl_chk
    import cache_pkg::*;
(
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cpu_ready,
    input logic                           mem_req,
    input logic                           mem_we,
    input logic                           mem_ack,
    input logic [LADDR_W-1:0]             mem_addr,
    input logic [WORDS-1:0]               mem_wmask,
    input logic [NUM_WAYS-1:0][WAY_W-1:0] lru_row
);
    logic [NUM_WAYS-1:0] seen;

    // which way numbers occur in the current set's recency list
    always_comb begin
        seen = '0;
        for (int i = 0; i < NUM_WAYS; i++) seen[lru_row[i]] = 1'b1;
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr)); // R11
    AST_STALL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready); // R4
    AST_WBACK_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack && (&mem_wmask) |=> mem_req && !mem_we); // R8
    AST_WMASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> ($countones(mem_wmask) == 1) || (&mem_wmask)); // R6
    AST_LRU_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        &seen); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !$past(rst_n) |-> !mem_req); // R10
endmodule

bind cache_ctrl cache_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wmask (mem_wmask),
    .lru_row   (lru_row)
);

// File: tb/sim_cache_ctrl.sv
// Self-checking bench for cache_ctrl: a flat shadow memory gives expected
// load data; a line-wide memory model with fixed latency answers misses.
module sim_cache_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         alloc_en = 1'b1;
    logic         cpu_valid = 1'b0;
    logic         cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic         cpu_ready;
    logic [31:0]  cpu_rdata;
    logic         mem_req, mem_we;
    logic [25:0]  mem_addr;
    logic [15:0]  mem_wmask;
    logic [511:0] mem_wdata;
    logic         mem_ack = 1'b0;
    logic [511:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int mcnt = 0;
    int log_n = 0;
    logic         log_w [256];
    logic [25:0]  log_a [256];
    logic [15:0]  log_m [256];
    logic [31:0]  back_m [int unsigned];
    logic [31:0]  shad_m [int unsigned];

    always #10 clk = ~clk; // 50 MHz

    cache_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wmask(mem_wmask), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_val(int unsigned wa);
        return (wa * 32'h9E37_79B1) ^ 32'h1357_2468;
    endfunction

    function automatic logic [31:0] rd_back(int unsigned wa);
        if (back_m.exists(wa)) return back_m[wa];
        return init_val(wa);
    endfunction

    function automatic logic [31:0] rd_shad(int unsigned wa);
        if (shad_m.exists(wa)) return shad_m[wa];
        return init_val(wa);
    endfunction

    // memory model: answers a held request after three cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mcnt    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            mcnt    <= 0;
        end else if (mem_req) begin
            if (mcnt == 2) begin
                mem_ack <= 1'b1;
                for (int w = 0; w < 16; w++) begin
                    int unsigned wa;
                    wa = 32'({mem_addr, 4'(w)});
                    if (mem_we && mem_wmask[w]) back_m[wa] = mem_wdata[w*32 +: 32];
                    mem_rdata[w*32 +: 32] <= rd_back(wa);
                end
                if (mem_we) wr_cnt++;
                if (log_n < 256) begin
                    log_w[log_n] = mem_we;
                    log_a[log_n] = mem_addr;
                    log_m[log_n] = mem_wmask;
                    log_n++;
                end
            end else begin
                mcnt <= mcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one processor access; returns wait cycles, load data, memory writes seen
    task automatic do_acc(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output int cyc, output logic [31:0] rd, output int nwr);
        int w0;
        w0 = wr_cnt;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        cyc = 0;
        #1;
        while (!cpu_ready && cyc < 300) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_valid = 1'b0; cpu_we = 1'b0;
        if (we) shad_m[32'(a[31:2])] = d;
        nwr = wr_cnt - w0;
    endtask

    // vector: {we, addr, wdata, expect_hit, expect_mem_writes}
    localparam int NV = 24;
    localparam logic [67:0] VEC [NV] = '{
        {1'b0, 32'h0000_0140, 32'h0,         1'b0, 2'd0}, // R1 R4 R10 t0 miss
        {1'b0, 32'h0000_0144, 32'h0,         1'b1, 2'd0}, // R1 R2 other word
        {1'b1, 32'h0000_0148, 32'hCAFE_0001, 1'b1, 2'd0}, // R3 write hit
        {1'b0, 32'h0000_0148, 32'h0,         1'b1, 2'd0}, // R3 read back
        {1'b0, 32'h0000_1140, 32'h0,         1'b0, 2'd0}, // R7 fill invalid ways
        {1'b0, 32'h0000_2140, 32'h0,         1'b0, 2'd0},
        {1'b0, 32'h0000_3140, 32'h0,         1'b0, 2'd0},
        {1'b0, 32'h0000_4140, 32'h0,         1'b0, 2'd0},
        {1'b0, 32'h0000_5140, 32'h0,         1'b0, 2'd0},
        {1'b0, 32'h0000_6140, 32'h0,         1'b0, 2'd0},
        {1'b0, 32'h0000_7140, 32'h0,         1'b0, 2'd0},
        {1'b0, 32'h0000_0140, 32'h0,         1'b1, 2'd0}, // R7 touch t0
        {1'b0, 32'h0000_8140, 32'h0,         1'b0, 2'd0}, // R7 R9 evict t1
        {1'b0, 32'h0000_0140, 32'h0,         1'b1, 2'd0}, // R7 t0 survives
        {1'b0, 32'h0000_1140, 32'h0,         1'b0, 2'd0}, // R7 t1 gone, evict t2
        {1'b0, 32'h0000_2140, 32'h0,         1'b0, 2'd0}, // R7 evict t3
        {1'b1, 32'h0000_A150, 32'hBEEF_0002, 1'b0, 2'd0}, // R5 allocate, evict t4
        {1'b0, 32'h0000_A150, 32'h0,         1'b1, 2'd0}, // R5 now cached
        {1'b0, 32'h0000_B140, 32'h0,         1'b0, 2'd0}, // evict t5
        {1'b0, 32'h0000_C140, 32'h0,         1'b0, 2'd0}, // evict t6
        {1'b0, 32'h0000_D140, 32'h0,         1'b0, 2'd0}, // evict t7
        {1'b0, 32'h0000_E140, 32'h0,         1'b0, 2'd0}, // evict t8
        {1'b0, 32'h0000_F140, 32'h0,         1'b0, 2'd1}, // R8 dirty t0 evicted
        {1'b0, 32'h0000_0148, 32'h0,         1'b0, 2'd0}  // R8 data came back
    };

    initial begin : main
        int cyc, nwr, lg0;
        logic [31:0] rd;
        lg0 = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(cpu_ready == 1'b1, "R10 ready after reset", 32'(cpu_ready), 32'd1);
        chk(mem_req == 1'b0, "R10 no request after reset", 32'(mem_req), 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic        v_we;
            logic [31:0] v_a, v_d;
            logic        v_hit;
            logic [1:0]  v_wr;
            {v_we, v_a, v_d, v_hit, v_wr} = VEC[i];
            if (v_wr != 0) lg0 = log_n;
            do_acc(v_we, v_a, v_d, cyc, rd, nwr);
            chk((cyc == 0) == v_hit, $sformatf("R2/R4 hit-or-miss vector %0d", i), 32'(cyc), 32'(v_hit ? 0 : 1));
            chk(nwr == int'(v_wr), $sformatf("R3/R9 memory writes vector %0d", i), 32'(nwr), 32'(v_wr));
            if (!v_we)
                chk(rd == rd_shad(32'(v_a[31:2])), $sformatf("R1 load data vector %0d", i), rd, rd_shad(32'(v_a[31:2])));
        end

        // R8: write-back of old line 0x5 precedes refill of line 0x3C5
        chk(log_w[lg0] == 1'b1 && log_a[lg0] == 26'h5, "R8 writeback first", 32'(log_a[lg0]), 32'h5);
        chk(log_m[lg0] == 16'hFFFF, "R8 full line mask", 32'(log_m[lg0]), 32'hFFFF);
        chk(log_w[lg0+1] == 1'b0 && log_a[lg0+1] == 26'h3C5, "R8 refill second", 32'(log_a[lg0+1]), 32'h3C5);
        chk(rd_back(32'h52) == 32'hCAFE_0001, "R8 memory holds dirty word", rd_back(32'h52), 32'hCAFE_0001);
        chk(rd_back(32'h2854) == init_val(32'h2854), "R5 allocated store not in memory", rd_back(32'h2854), init_val(32'h2854));

        // R6: write miss without allocation
        alloc_en = 1'b0;
        lg0 = log_n;
        do_acc(1'b1, 32'h0002_0344, 32'h5555_AAAA, cyc, rd, nwr);
        chk(nwr == 1, "R6 one memory write", 32'(nwr), 32'd1);
        chk(log_n == lg0 + 1, "R6 no refill", 32'(log_n - lg0), 32'd1);
        chk(log_a[lg0] == 26'h80D && log_m[lg0] == 16'h0002, "R6 address and word mask",
            {log_a[lg0][15:0], log_m[lg0]}, {16'h080D, 16'h0002});
        chk(rd_back(32'h80D1) == 32'h5555_AAAA, "R6 memory word", rd_back(32'h80D1), 32'h5555_AAAA);
        do_acc(1'b0, 32'h0002_0344, 32'h0, cyc, rd, nwr);
        chk(cyc > 0, "R6 later read misses", 32'(cyc), 32'd1);
        chk(rd == 32'h5555_AAAA, "R6 later read data", rd, 32'h5555_AAAA);
        do_acc(1'b1, 32'h0002_0348, 32'h7777_0003, cyc, rd, nwr);
        chk(cyc == 0 && nwr == 0, "R3 write hit with allocation off", 32'(cyc + nwr), 32'd0);
        do_acc(1'b0, 32'h0002_0348, 32'h0, cyc, rd, nwr);
        chk(rd == 32'h7777_0003, "R3 word updated", rd, 32'h7777_0003);

        // R10: reset clears every valid bit
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(cpu_ready == 1'b1 && mem_req == 1'b0, "R10 idle after second reset",
            {31'd0, cpu_ready}, 32'd1);
        do_acc(1'b0, 32'h0002_0344, 32'h0, cyc, rd, nwr);
        chk(cyc > 0, "R10 miss after reset", 32'(cyc), 32'd1);
        chk(rd == 32'h5555_AAAA, "R10 refetched data", rd, 32'h5555_AAAA);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule